// File: doc/BRIEF.md
# Mailbox Word Write Port with Running CRC-16

This block lets a host on a 16-bit register bus place 32-bit words into an on-chip memory. The host loads a target address and a data word as two 16-bit halves each, then issues a command that commits the word. The block drives a one-cycle memory write strobe with that address and word, then steps the address on by one word. A host therefore sets the address once per section and streams words into it. A program image is typically loaded as two sections, one based at 0x3FFE0000 and one based at 0x40000000.

Each committed word is also folded into a running CRC-16. The CRC uses polynomial 0x1021 and is not reflected. The word enters most-significant byte first, even though the host builds the word from little-endian data. The host clears this CRC through the command register and reads it back through a dedicated register. After loading a section, the host compares the CRC the block reports with the one it computed itself.

The register offsets are: 0 is the command register, 1 is the CRC readback (read-only), 2 is the address upper half, 3 is the address lower half, 4 is the data upper half and 5 is the data lower half. Offsets 6 and 7 are unmapped. The command register uses three bits: bit 15 is execute, bit 14 is write and bit 12 is CRC clear. Read data appears on the cycle after a read strobe and holds until the next read.

Top module: `mbox_wport`

## Requirements
- R1: After reset, mem_we is 0, the running CRC is 0x0000, the current address is 0, and reg_rdata is 0.
- R2: A write to offset 2 sets address bits 31:16, and a write to offset 3 sets address bits 15:0. Reading offsets 2 and 3 returns the current address halves.
- R3: A write to offset 4 sets data bits 31:16, and a write to offset 5 sets data bits 15:0. Reading offsets 4 and 5 returns the stored halves.
- R4: A write to offset 0 with bit 15 (execute) and bit 14 (write) both set commits the word. On the next cycle, mem_we is 1 for exactly one cycle, with mem_addr equal to the current address and mem_data equal to {data upper, data lower}.
- R5: A command write with only bit 15 set, or only bit 14 set, produces no memory write. It also leaves the address and the CRC unchanged.
- R6: Each commit advances the current address by 4 and wraps modulo 2^32, so 0xFFFFFFFC steps to 0x00000000.
- R7: Each commit folds the word into the CRC as four bytes, bits 31:24 first, using polynomial 0x1021 (not reflected). The new value is readable at offset 1 from the cycle after the commit.
- R8: A command write with bit 12 set clears the CRC to 0x0000. If the same write also commits, the CRC is cleared first and the word is then folded in.
- R9: Reading offset 0 returns 0x0000, because command bits are not stored.
- R10: Address bits 1:0 are always 0 on mem_addr and in the offset 3 readback, whatever value the host writes.
- R11: These writes have no effect on the address, the data, the CRC or mem_we: a write to offset 1, a write to offset 6 or 7, and any bus activity with reg_we low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_re |
| mem_addr | output | 32 | Memory write byte address (word aligned) |
| mem_data | output | 32 | Memory write word |
| mem_we | output | 1 | One-cycle memory write strobe |

## Verification
The bench streams words with distinct byte patterns into the data window and checks the CRC against a bit-serial model. A design that folds the word least-significant byte first passes only symmetric words such as all-zeros and all-ones, and fails on the rest. Partial commands (execute alone, write alone) would show up as spurious write strobes or address steps. The combined clear-and-commit case would expose a design that applies the clear after the fold, leaving 0x0000 instead of the fold of the word. The address wrap at 0xFFFFFFFC, misaligned low-half writes, and writes to the read-only and unmapped offsets would catch a carry leaking into the upper half, address bits 1:0 reaching the memory port, or a decoder that is too loose.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int RA_W  = 3;
    localparam int CRC_W = 16;

    typedef enum logic [RA_W-1:0] {
        RG_CMD     = 3'd0,
        RG_CRC     = 3'd1,
        RG_ADDR_HI = 3'd2,
        RG_ADDR_LO = 3'd3,
        RG_DATA_HI = 3'd4,
        RG_DATA_LO = 3'd5
    } reg_sel_e;

    localparam int CMD_EXEC_BIT  = 15;
    localparam int CMD_WRITE_BIT = 14;
    localparam int CMD_CLR_BIT   = 12;

    // One byte of an MSB-first, non-reflected CRC-16 update.
    function automatic logic [CRC_W-1:0] crc_byte_step(
        input logic [CRC_W-1:0] c,
        input logic [7:0]       b,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) begin
            r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode
    import mbox_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic              wr_addr_hi,
    output logic              wr_addr_lo,
    output logic              wr_data_hi,
    output logic              wr_data_lo,
    output logic              do_commit,
    output logic              do_clear
);
    logic cmd_hit;

    always_comb begin
        cmd_hit    = reg_we && (reg_addr == RG_CMD);
        wr_addr_hi = reg_we && (reg_addr == RG_ADDR_HI);
        wr_addr_lo = reg_we && (reg_addr == RG_ADDR_LO);
        wr_data_hi = reg_we && (reg_addr == RG_DATA_HI);
        wr_data_lo = reg_we && (reg_addr == RG_DATA_LO);
        do_commit  = cmd_hit && reg_wdata[CMD_EXEC_BIT] && reg_wdata[CMD_WRITE_BIT];
        do_clear   = cmd_hit && reg_wdata[CMD_CLR_BIT];
    end
endmodule

// File: rtl/mbox_crc_fold.sv
module mbox_crc_fold
    import mbox_pkg::*;
#(
    parameter int               NBYTES = 4,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021
) (
    input  logic [CRC_W-1:0]    crc_in,
    input  logic [NBYTES*8-1:0] word,
    output logic [CRC_W-1:0]    crc_out
);
    logic [CRC_W-1:0] stage [NBYTES+1];

    assign stage[0] = crc_in;

    // Most-significant byte enters the chain first.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign stage[i+1] = crc_byte_step(stage[i], word[(NBYTES-1-i)*8 +: 8], POLY);
    end

    assign crc_out = stage[NBYTES];
endmodule

// File: rtl/mbox_read_mux.sv
module mbox_read_mux
    import mbox_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [RA_W-1:0]     sel,
    input  logic [WORD_W-1:0]   cur_addr,
    input  logic [WORD_W/2-1:0] data_hi,
    input  logic [WORD_W/2-1:0] data_lo,
    input  logic [CRC_W-1:0]    crc,
    output logic [WORD_W/2-1:0] rdata
);
    localparam int HALF_W = WORD_W / 2;

    always_comb begin
        rdata = '0;
        unique case (sel)
            RG_CRC:     rdata = HALF_W'(crc);
            RG_ADDR_HI: rdata = cur_addr[WORD_W-1:HALF_W];
            RG_ADDR_LO: rdata = cur_addr[HALF_W-1:0];
            RG_DATA_HI: rdata = data_hi;
            RG_DATA_LO: rdata = data_lo;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_wport.sv
module mbox_wport
    import mbox_pkg::*;
#(
    parameter int               WORD_W   = 32,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          reg_addr,
    input  logic [WORD_W/2-1:0] reg_wdata,
    input  logic                reg_we,
    input  logic                reg_re,
    output logic [WORD_W/2-1:0] reg_rdata,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_data,
    output logic                mem_we
);
    localparam int HALF_W  = WORD_W / 2;
    localparam int NBYTES  = WORD_W / 8;
    localparam int ALIGN_W = $clog2(NBYTES);

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [HALF_W-1:0] dhi;
        logic [HALF_W-1:0] dlo;
        logic [CRC_W-1:0]  crc;
        logic              mem_we;
        logic [WORD_W-1:0] mem_addr;
        logic [WORD_W-1:0] mem_data;
        logic [HALF_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic              wr_addr_hi, wr_addr_lo, wr_data_hi, wr_data_lo;
    logic              do_commit, do_clear;
    logic [WORD_W-1:0] cur_addr;
    logic [CRC_W-1:0]  crc_cur, crc_base, crc_next;
    logic [HALF_W-1:0] rd_val;

    assign cur_addr = st_q.addr;
    assign crc_cur  = st_q.crc;
    assign crc_base = do_clear ? '0 : st_q.crc;

    mbox_cmd_decode #(.HALF_W(HALF_W)) i_dec (
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .wr_addr_hi (wr_addr_hi),
        .wr_addr_lo (wr_addr_lo),
        .wr_data_hi (wr_data_hi),
        .wr_data_lo (wr_data_lo),
        .do_commit  (do_commit),
        .do_clear   (do_clear)
    );

    mbox_crc_fold #(.NBYTES(NBYTES), .POLY(CRC_POLY)) i_fold (
        .crc_in  (crc_base),
        .word    ({st_q.dhi, st_q.dlo}),
        .crc_out (crc_next)
    );

    mbox_read_mux #(.WORD_W(WORD_W)) i_rmux (
        .sel      (reg_addr),
        .cur_addr (cur_addr),
        .data_hi  (st_q.dhi),
        .data_lo  (st_q.dlo),
        .crc      (crc_cur),
        .rdata    (rd_val)
    );

    always_comb begin
        st_d        = st_q;
        st_d.mem_we = 1'b0;

        if (wr_addr_hi) st_d.addr[WORD_W-1:HALF_W] = reg_wdata;
        if (wr_addr_lo) st_d.addr[HALF_W-1:0]      = {reg_wdata[HALF_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        if (wr_data_hi) st_d.dhi = reg_wdata;
        if (wr_data_lo) st_d.dlo = reg_wdata;

        if (do_commit) begin
            st_d.mem_we   = 1'b1;
            st_d.mem_addr = st_q.addr;
            st_d.mem_data = {st_q.dhi, st_q.dlo};
            st_d.addr     = st_q.addr + WORD_W'(NBYTES);
            st_d.crc      = crc_next;
        end else if (do_clear) begin
            st_d.crc      = '0;
        end

        if (reg_re) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign mem_addr  = st_q.mem_addr;
    assign mem_data  = st_q.mem_data;
    assign mem_we    = st_q.mem_we;
endmodule

// File: rtl/mbox_wport_chk.sv
module mbox_wport_chk #(
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          reg_addr,
    input logic [WORD_W/2-1:0] reg_wdata,
    input logic                reg_we,
    input logic                reg_re,
    input logic [WORD_W/2-1:0] reg_rdata,
    input logic [WORD_W-1:0]   mem_addr,
    input logic                mem_we,
    input logic [WORD_W-1:0]   cur_addr,
    input logic [15:0]         crc_cur,
    input logic                do_commit,
    input logic                do_clear
);
    p_commit_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && reg_wdata[15] && reg_wdata[14]) |=> mem_we);

    p_no_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !do_commit |=> !mem_we);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cur_addr == mem_addr + WORD_W'(4)));

    p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_commit && !do_clear) |=> $stable(crc_cur));

    p_crc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_clear && !do_commit) |=> (crc_cur == 16'h0000));

    p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == 3'd0) |=> (reg_rdata == '0));

    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[1:0] == 2'b00) && (cur_addr[1:0] == 2'b00));
endmodule

bind mbox_wport mbox_wport_chk #(.WORD_W(WORD_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .cur_addr  (cur_addr),
    .crc_cur   (crc_cur),
    .do_commit (do_commit),
    .do_clear  (do_clear)
);

// File: tb/test_mbox_wport.sv
module test_mbox_wport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [15:0] reg_rdata;
    logic [31:0] mem_addr, mem_data;
    logic        mem_we;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_addr;
    logic [15:0] exp_crc;
    logic [15:0] rv;

    always #2 clk = ~clk;

    mbox_wport i_mbox_wport (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we)
    );

    localparam logic [31:0] VEC [6] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
        32'hDEAD_BEEF, 32'h8000_0001, 32'h0102_0304
    };

    // Bit-serial reference: 32 bits, MSB first, poly 0x1021.
    function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r = c;
        for (int b = 31; b >= 0; b--) begin
            logic fb = r[15] ^ w[b];
            r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        v = reg_rdata;
    endtask

    task automatic set_addr(input logic [31:0] a);
        wr(3'd2, a[31:16]);
        wr(3'd3, a[15:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        chk("R1 rdata", {16'd0, reg_rdata}, 32'd0);
        rd(3'd1, rv); chk("R1 crc", {16'd0, rv}, 32'd0);
        rd(3'd2, rv); chk("R1 addr hi", {16'd0, rv}, 32'd0);

        // Table walk: stream into data window
        exp_addr = 32'h3FFE_0000;
        exp_crc  = 16'h0000;
        set_addr(exp_addr);
        rd(3'd2, rv); chk("R2 addr hi", {16'd0, rv}, 32'h3FFE);
        rd(3'd3, rv); chk("R2 addr lo", {16'd0, rv}, 32'h0000);
        wr(3'd0, 16'h1000);
        for (int i = 0; i < 6; i++) begin
            wr(3'd4, VEC[i][31:16]);
            wr(3'd5, VEC[i][15:0]);
            wr(3'd0, 16'hC000);
            chk("R4 mem_we", {31'd0, mem_we}, 32'd1);
            chk("R4 mem_addr", mem_addr, exp_addr);
            chk("R4 mem_data", mem_data, VEC[i]);
            exp_addr = exp_addr + 32'd4;
            exp_crc  = model_crc(exp_crc, VEC[i]);
            rd(3'd1, rv); chk("R7 crc", {16'd0, rv}, {16'd0, exp_crc});
            chk("R4 strobe single cycle", {31'd0, mem_we}, 32'd0);
        end
        rd(3'd2, rv); chk("R6 addr hi after stream", {16'd0, rv}, {16'd0, exp_addr[31:16]});
        rd(3'd3, rv); chk("R6 addr lo after stream", {16'd0, rv}, {16'd0, exp_addr[15:0]});
        rd(3'd4, rv); chk("R3 data hi", {16'd0, rv}, 32'h0102);
        rd(3'd5, rv); chk("R3 data lo", {16'd0, rv}, 32'h0304);

        // R5 partial commands
        wr(3'd0, 16'h8000);
        chk("R5 exec only", {31'd0, mem_we}, 32'd0);
        wr(3'd0, 16'h4000);
        chk("R5 write only", {31'd0, mem_we}, 32'd0);
        rd(3'd3, rv); chk("R5 addr unchanged", {16'd0, rv}, {16'd0, exp_addr[15:0]});
        rd(3'd1, rv); chk("R5 crc unchanged", {16'd0, rv}, {16'd0, exp_crc});

        // R11 ignored writes
        wr(3'd1, 16'hABCD);
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        @(negedge clk);
        reg_addr = 3'd3; reg_wdata = 16'h5550;
        @(negedge clk);
        rd(3'd1, rv); chk("R11 crc untouched", {16'd0, rv}, {16'd0, exp_crc});
        rd(3'd3, rv); chk("R11 addr untouched", {16'd0, rv}, {16'd0, exp_addr[15:0]});
        rd(3'd5, rv); chk("R11 data untouched", {16'd0, rv}, 32'h0304);

        // R9 command reads zero
        rd(3'd0, rv); chk("R9 cmd read", {16'd0, rv}, 32'd0);

        // R8 clear alone, then clear with commit
        wr(3'd0, 16'h1000);
        rd(3'd1, rv); chk("R8 clear", {16'd0, rv}, 32'd0);
        wr(3'd4, 16'hCAFE); wr(3'd5, 16'hF00D);
        wr(3'd0, 16'h4000); wr(3'd0, 16'hC000);
        wr(3'd0, 16'hD000);
        chk("R8 commit with clear", {31'd0, mem_we}, 32'd1);
        rd(3'd1, rv);
        chk("R8 clear then fold", {16'd0, rv}, {16'd0, model_crc(16'h0000, 32'hCAFE_F00D)});

        // R10 alignment, instruction window
        set_addr(32'h4000_0007);
        rd(3'd3, rv); chk("R10 lo readback", {16'd0, rv}, 32'h0004);
        wr(3'd0, 16'hC000);
        chk("R10 mem_addr aligned", mem_addr, 32'h4000_0004);

        // R6 wrap
        set_addr(32'hFFFF_FFFC);
        wr(3'd0, 16'hC000);
        chk("R6 wrap commit addr", mem_addr, 32'hFFFF_FFFC);
        rd(3'd2, rv); chk("R6 wrap hi", {16'd0, rv}, 32'd0);
        rd(3'd3, rv); chk("R6 wrap lo", {16'd0, rv}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule